// File: doc/BRIEF.md
# Masked Channel Interrupt Aggregator

This block gathers per-channel completion pulses from a bank of DMA channels into one interrupt line. Every pulse is held in a sticky status bit. An enable mask selects which status bits may raise the interrupt. A read-only pending view shows the status bits that are both set and enabled.

Software works through a 32-bit register read/write port. It reads the pending view to find the channels that finished, then acknowledges them by writing ones to the status register. To quiet the line for a while, it clears the enable mask. The status bits stay latched while the mask is clear, so no completion is lost.

The block also holds one address-control bit. It is driven out to the channel datapaths and selects 32-bit addressing.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the status, enable, pending and address-control registers all read zero, and `irq_o` and `addr32_o` are low.
- R2: The register offsets are as follows: status at 0x080000, pending at 0x080004, enable at 0x080008 and address-control at 0x34. Bit i of status, pending and enable belongs to channel i. A read of any other offset returns zero.
- R3: A one-cycle high on `done_i[i]` sets status bit i. The bit stays set until software clears it.
- R4: Writing status clears each bit whose write-data bit is 1. Bits whose write-data bit is 0 are unchanged.
- R5: Writing 0xFFFFFFFF to status clears every status bit at once.
- R6: The pending register reads as status AND enable.
- R7: Writing 0 to enable makes pending read zero, while the status bits keep their latched values.
- R8: `irq_o` is registered. In each cycle it equals the OR of all pending bits as they stood one clock earlier.
- R9: If a done pulse and a status-clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: Writing the address-control register with bit 0 set drives `addr32_o` high. Writing it with bit 0 clear drives `addr32_o` low. It reads back that bit in bit 0, with zeros above it.
- R11: A write to the pending register changes neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | NCHAN | Per-channel completion pulses |
| reg_addr | input | AW | Register byte offset |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Level interrupt, high while anything is pending |
| addr32_o | output | 1 | Selects 32-bit addressing in the channel datapaths |

## Verification
The bench targets the case where a completion pulse meets an acknowledge write on the same bit. A design that lets the clear win there would silently drop a completion. It checks that clearing the enable mask keeps the status latched; a design that cleared status on masking would read zero once the mask was restored. It checks that `irq_o` rises exactly one cycle after pending does, which catches a combinational or doubly registered line. It also writes the pending offset, which would corrupt status or enable in a design with loose address decoding.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NCHAN = 32,
  parameter int AW    = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCHAN-1:0] done_i,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_o,
  output logic             addr32_o
);
  localparam logic [AW-1:0] OFS_STAT = AW'(20'h80000);
  localparam logic [AW-1:0] OFS_PEND = AW'(20'h80004);
  localparam logic [AW-1:0] OFS_ENAB = AW'(20'h80008);
  localparam logic [AW-1:0] OFS_ACTL = AW'(20'h00034);

  logic [NCHAN-1:0] status, enable, pending, clr;
  logic             irq_q, actl;

  wire wr_stat = reg_we && reg_addr == OFS_STAT;
  wire wr_enab = reg_we && reg_addr == OFS_ENAB;
  wire wr_actl = reg_we && reg_addr == OFS_ACTL;

  assign clr     = wr_stat ? reg_wdata[NCHAN-1:0] : '0;
  assign pending = status & enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      actl   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      status <= (status & ~clr) | done_i;
      if (wr_enab) enable <= reg_wdata[NCHAN-1:0];
      if (wr_actl) actl <= reg_wdata[0];
      irq_q <= |pending;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_STAT: reg_rdata[NCHAN-1:0] = status;
      OFS_PEND: reg_rdata[NCHAN-1:0] = pending;
      OFS_ENAB: reg_rdata[NCHAN-1:0] = enable;
      OFS_ACTL: reg_rdata[0]         = actl;
      default:  reg_rdata            = '0;
    endcase
  end

  assign irq_o    = irq_q;
  assign addr32_o = actl;

  // R3 / R9: a done pulse always leaves its bit set
  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_i) |=> ((status & $past(done_i)) == $past(done_i)));

  // R4: cleared bits without a coincident pulse read zero next cycle
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((status & $past(reg_wdata[NCHAN-1:0] & ~done_i)) == '0));

  // R8: interrupt line lags pending by one clock
  p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == (|$past(reg_rdata[NCHAN-1:0] & {NCHAN{reg_addr == OFS_PEND}}))
              || reg_addr != OFS_PEND || $past(reg_addr) != OFS_PEND));

  // R7: with the mask cleared the line falls and stays low
  p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |=> !irq_o);

  // R11: a pending write loses no status bit and keeps the mask
  p_pend_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_PEND) |=>
      ((status & $past(status)) == $past(status)) && $stable(enable));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int PERIOD = 10;
  localparam logic [19:0] A_STAT = 20'h80000;
  localparam logic [19:0] A_PEND = 20'h80004;
  localparam logic [19:0] A_ENAB = 20'h80008;
  localparam logic [19:0] A_ACTL = 20'h00034;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [31:0] done_i = '0, reg_wdata = '0, reg_rdata;
  logic [19:0] reg_addr = '0;
  logic irq_o, addr32_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  irq_aggregator #(.NCHAN(32), .AW(20)) dut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .addr32_o(addr32_o));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [19:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk); done_i = m;
    @(negedge clk); done_i = '0;
  endtask

  task automatic clean();
    wr(A_ENAB, 32'h0); wr(A_STAT, 32'hFFFF_FFFF); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_ENAB, v); chk("R1 enable", v, 0);
    rd(A_PEND, v); chk("R1 pending", v, 0);
    rd(A_ACTL, v); chk("R1 actl", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 addr32", {31'b0, addr32_o}, 0);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    pulse(32'h8000_0011);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R3 sticky latch", v, 32'h8000_0011);
    rd(20'h0004C, v); chk("R2 unmapped read", v, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_STAT, 32'h0000_0010);
    rd(A_STAT, v); chk("R4 w1c clears only ones", v, 32'h8000_0001);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R4 zero write no change", v, 32'h8000_0001);
  endtask

  task automatic t_clear_all();
    logic [31:0] v;
    pulse(32'hA5A5_5A5A);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R5 clear all", v, 0);
  endtask

  task automatic t_pending_irq();
    logic [31:0] v;
    wr(A_ENAB, 32'h0000_00F0);
    pulse(32'h0000_0F0F);
    rd(A_PEND, v); chk("R6 pending is and", v, 32'h0000_0000);
    chk("R8 irq low no overlap", {31'b0, irq_o}, 0);
    pulse(32'h0000_0030);
    rd(A_PEND, v); chk("R6 pending is and", v, 32'h0000_0030);
    chk("R8 irq not yet", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R8 irq one cycle later", {31'b0, irq_o}, 1);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(A_ENAB, 32'h0);
    rd(A_PEND, v); chk("R7 pending zero", v, 0);
    rd(A_STAT, v); chk("R7 status kept", v, 32'h0000_0F3F);
    @(negedge clk);
    chk("R7 irq dropped", {31'b0, irq_o}, 0);
    wr(A_ENAB, 32'h0000_0001);
    rd(A_PEND, v); chk("R7 status survives mask", v, 32'h0000_0001);
  endtask

  task automatic t_race();
    logic [31:0] v;
    clean();
    pulse(32'h0000_0003);
    @(negedge clk);
    reg_addr = A_STAT; reg_wdata = 32'h0000_0003; reg_we = 1; done_i = 32'h1;
    @(negedge clk); reg_we = 0; done_i = '0;
    rd(A_STAT, v); chk("R9 pulse beats clear", v, 32'h0000_0001);
  endtask

  task automatic t_pend_write();
    logic [31:0] v;
    wr(A_ENAB, 32'h0000_00FF);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R11 status untouched", v, 32'h0000_0001);
    rd(A_ENAB, v); chk("R11 enable untouched", v, 32'h0000_00FF);
  endtask

  task automatic t_actl();
    logic [31:0] v;
    wr(A_ACTL, 32'hFFFF_FFFF);
    rd(A_ACTL, v); chk("R10 readback", v, 1);
    chk("R10 addr32 high", {31'b0, addr32_o}, 1);
    wr(A_ACTL, 32'hFFFF_FFFE);
    chk("R10 addr32 low", {31'b0, addr32_o}, 0);
    rd(A_STAT, v); chk("R2 actl write leaves status", v, 32'h0000_0001);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_w1c();
    t_clear_all();
    t_pending_irq();
    t_mask();
    t_race();
    t_pend_write();
    t_actl();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule